// File: doc/BRIEF.md
# Video Memory Write Queue

This block sits between a host data port and three video memories: a byte-wide pattern memory (VRAM), a colour memory (CRAM) and a vertical-scroll memory (VSRAM). Host data writes are not performed at once. Each one is placed in a small queue together with the current target code, the current address, the data word and a ready time. The address register then advances by a programmable step.

The queue is drained only in external access slots, which a slot strobe input marks. In each slot the block grants the access to a pending read if there is one. Otherwise it services the oldest queued entry, provided that entry has aged enough, and drives a single memory write. A 16-bit VRAM entry needs two slots. The high byte goes first, the entry remains at the head, and the low byte follows in a later slot.

The block keeps the last data word that completed a write and reports when the queue is empty or full. The full flag pushes back on the host.

Top module: `vmem_write_queue`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fifo_empty` is 1, `fifo_full` is 0, `last_value` is 0 and `mem_we` is 0.
- R2: A host write is accepted (`host_accept`=1) exactly when `host_wr`=1, `cfg_load`=0, bit 0 of the held target code is 1, the queue is not full, and DMA is not blocking. DMA blocks when `dma_active`=1 and `dma_mode`≠2'b10 (2'b10 is fill mode). Every accepted write advances the held address by `autoinc`, modulo 2^16. `cfg_load` loads the held code and address.
- R3: The queue holds DEPTH entries (default 4) and retires them in first-in, first-out order. `fifo_empty` and `fifo_full` reflect the entry count registered at the previous clock edge.
- R4: An entry written in the cycle where the internal cycle count is c becomes serviceable when the count reaches c+SETTLE (default 2). The count starts at 0 after reset. Writes reach the memories only in cycles where `slot_strobe`=1.
- R5: When a read is pending, a slot goes to the read. `slot_unused`=1, no memory write occurs, and the pending flag clears unless `rd_req` sets it again in that same cycle. `rd_req` sets the flag.
- R6: A slot with no pending read and no serviceable head entry raises `slot_unused` and performs no write.
- R7: Code 4'h1 selects a VRAM write (`mem_target`=0). The first slot writes value[15:8] to the entry address, and the entry stays at the head. The next service writes value[7:0] to address XOR 1 and retires the entry. The byte appears on `mem_wdata[7:0]`, and bits 15:8 are 0.
- R8: Code 4'h3 selects a CRAM write (`mem_target`=1). The write goes to word index address[6:1] masked to CRAM_DEPTH-1, carries the full 16-bit value, and retires the entry.
- R9: Code 4'h5 selects a VSRAM write (`mem_target`=2). It uses word index address[6:1]. The write is performed only if the index is below VS_DEPTH (default 40). Otherwise the entry is retired without a write, and the slot is still consumed (`slot_unused`=0).
- R10: `last_value` takes the entry's 16-bit value on every CRAM write, every performed VSRAM write and every VRAM low-byte write. It holds in all other cycles.
- R11: An entry whose code is any other odd value is retired in its slot without a memory write and without changing `last_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load held target code and address |
| cfg_code | input | 4 | Target code to load |
| cfg_addr | input | 16 | Address to load |
| autoinc | input | 8 | Address step after each accepted write |
| dma_active | input | 1 | DMA is running |
| dma_mode | input | 2 | DMA mode bits, 2'b10 = fill |
| host_wr | input | 1 | Host data write request |
| host_data | input | 16 | Host data word |
| host_accept | output | 1 | Host write taken into the queue this cycle |
| rd_req | input | 1 | Sets the read-pending flag |
| slot_strobe | input | 1 | External access slot this cycle |
| slot_unused | output | 1 | Slot not used for a queued write |
| mem_we | output | 1 | Memory write strobe |
| mem_target | output | 2 | 0 VRAM, 1 CRAM, 2 VSRAM |
| mem_addr | output | 16 | Byte address (VRAM) or word index |
| mem_wdata | output | 16 | Write data |
| last_value | output | 16 | Value of the last completed write |
| fifo_empty | output | 1 | Queue empty |
| fifo_full | output | 1 | Queue full |

## Verification
The assertions assume that `cfg_load` and `host_wr` come from one host port, that `rd_req` is a pulse from the read side, and that `slot_strobe` can arrive in any cycle, including back to back. They also assume that the bench never runs long enough for the 16-bit ready-time comparison to alias. The stimulus runs far fewer cycles than 2^15, so entries never sit long enough to wrap. It mixes directed sequences with random traffic in which loads, writes, reads, DMA states and slots appear in arbitrary combinations, including all of them at once.

// File: rtl/vwq_pkg.sv
package vwq_pkg;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int SW = 16;

    typedef enum logic [1:0] {
        TGT_VRAM  = 2'd0,
        TGT_CRAM  = 2'd1,
        TGT_VSRAM = 2'd2,
        TGT_NONE  = 2'd3
    } tgt_e;

    localparam logic [3:0] CODE_VRAM_WR  = 4'h1;
    localparam logic [3:0] CODE_CRAM_WR  = 4'h3;
    localparam logic [3:0] CODE_VSRAM_WR = 4'h5;
    localparam logic [1:0] DMA_FILL      = 2'b10;

    typedef struct packed {
        logic [3:0]    code;
        logic [AW-1:0] addr;
        logic [DW-1:0] value;
        logic [SW-1:0] stamp;
        logic          partial;
    } entry_t;

    function automatic logic is_ready(input logic [SW-1:0] now, input logic [SW-1:0] stamp);
        logic [SW-1:0] diff;
        diff = now - stamp;
        return ~diff[SW-1];
    endfunction

    function automatic logic [5:0] word_idx(input logic [AW-1:0] a);
        return a[6:1];
    endfunction
endpackage

// File: rtl/vwq_host.sv
module vwq_host
    import vwq_pkg::*;
#(
    parameter int AIW    = 8,
    parameter int SETTLE = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_load,
    input  logic [3:0]     cfg_code,
    input  logic [AW-1:0]  cfg_addr,
    input  logic [AIW-1:0] autoinc,
    input  logic           dma_active,
    input  logic [1:0]     dma_mode,
    input  logic           host_wr,
    input  logic [DW-1:0]  host_data,
    input  logic [SW-1:0]  cyc,
    input  logic           full,
    output logic           accept,
    output entry_t         push_entry
);
    logic [3:0]    code_q;
    logic [AW-1:0] addr_q;
    logic          dma_block;

    assign dma_block = dma_active && (dma_mode != DMA_FILL);
    assign accept    = host_wr && !cfg_load && code_q[0] && !full && !dma_block;

    always_comb begin
        push_entry.code    = code_q;
        push_entry.addr    = addr_q;
        push_entry.value   = host_data;
        push_entry.stamp   = cyc + SW'(SETTLE);
        push_entry.partial = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            addr_q <= '0;
        end else if (cfg_load) begin
            code_q <= cfg_code;
            addr_q <= cfg_addr;
        end else if (accept) begin
            addr_q <= addr_q + AW'(autoinc);
        end
    end
endmodule

// File: rtl/vwq_fifo.sv
module vwq_fifo
    import vwq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  entry_t push_entry,
    input  logic   pop,
    input  logic   mark,
    output entry_t head,
    output logic   empty,
    output logic   full
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    entry_t        mem [DEPTH];
    logic [PW-1:0] wp;
    logic [PW-1:0] rp;
    logic [CW-1:0] cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign head  = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) begin
                mem[wp] <= push_entry;
                wp      <= wp + PW'(1);
            end
            if (mark) begin
                mem[rp].partial <= 1'b1;
            end
            if (pop) begin
                rp <= rp + PW'(1);
            end
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/vwq_slot.sv
module vwq_slot
    import vwq_pkg::*;
#(
    parameter int CRAM_DEPTH = 64,
    parameter int VS_DEPTH   = 40
) (
    input  logic          slot,
    input  logic          rd_pend,
    input  logic          empty,
    input  entry_t        head,
    input  logic [SW-1:0] cyc,
    output logic          we,
    output tgt_e          tgt,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          pop,
    output logic          mark,
    output logic          last_we,
    output logic          unused
);
    localparam logic [5:0] CMASK = 6'(CRAM_DEPTH - 1);

    logic       ready;
    logic       serve;
    logic [5:0] idx;

    assign ready  = !empty && is_ready(cyc, head.stamp);
    assign serve  = slot && !rd_pend && ready;
    assign unused = slot && (rd_pend || !ready);
    assign idx    = word_idx(head.addr);

    always_comb begin
        we      = 1'b0;
        tgt     = TGT_NONE;
        addr    = '0;
        wdata   = '0;
        pop     = 1'b0;
        mark    = 1'b0;
        last_we = 1'b0;
        if (serve) begin
            case (head.code)
                CODE_VRAM_WR: begin
                    we  = 1'b1;
                    tgt = TGT_VRAM;
                    if (!head.partial) begin
                        addr  = head.addr;
                        wdata = {8'h00, head.value[15:8]};
                        mark  = 1'b1;
                    end else begin
                        addr    = head.addr ^ AW'(1);
                        wdata   = {8'h00, head.value[7:0]};
                        pop     = 1'b1;
                        last_we = 1'b1;
                    end
                end
                CODE_CRAM_WR: begin
                    we      = 1'b1;
                    tgt     = TGT_CRAM;
                    addr    = AW'(idx & CMASK);
                    wdata   = head.value;
                    pop     = 1'b1;
                    last_we = 1'b1;
                end
                CODE_VSRAM_WR: begin
                    pop = 1'b1;
                    if (int'(idx) < VS_DEPTH) begin
                        we      = 1'b1;
                        tgt     = TGT_VSRAM;
                        addr    = AW'(idx);
                        wdata   = head.value;
                        last_we = 1'b1;
                    end
                end
                default: pop = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/vmem_write_queue.sv
module vmem_write_queue
    import vwq_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int SETTLE     = 2,
    parameter int AIW        = 8,
    parameter int CRAM_DEPTH = 64,
    parameter int VS_DEPTH   = 40
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_load,
    input  logic [3:0]     cfg_code,
    input  logic [15:0]    cfg_addr,
    input  logic [AIW-1:0] autoinc,
    input  logic           dma_active,
    input  logic [1:0]     dma_mode,
    input  logic           host_wr,
    input  logic [15:0]    host_data,
    output logic           host_accept,
    input  logic           rd_req,
    input  logic           slot_strobe,
    output logic           slot_unused,
    output logic           mem_we,
    output logic [1:0]     mem_target,
    output logic [15:0]    mem_addr,
    output logic [15:0]    mem_wdata,
    output logic [15:0]    last_value,
    output logic           fifo_empty,
    output logic           fifo_full
);
    logic [SW-1:0] cyc;
    logic          rd_pend;
    entry_t        push_entry;
    entry_t        head;
    logic          fifo_pop;
    logic          fifo_mark;
    logic          last_we;
    tgt_e          tgt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc        <= '0;
            rd_pend    <= 1'b0;
            last_value <= '0;
        end else begin
            cyc     <= cyc + SW'(1);
            rd_pend <= (rd_pend && !slot_strobe) || rd_req;
            if (last_we) begin
                last_value <= head.value;
            end
        end
    end

    vwq_host #(.AIW(AIW), .SETTLE(SETTLE)) u_host (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_code(cfg_code),
        .cfg_addr(cfg_addr), .autoinc(autoinc), .dma_active(dma_active),
        .dma_mode(dma_mode), .host_wr(host_wr), .host_data(host_data),
        .cyc(cyc), .full(fifo_full), .accept(host_accept), .push_entry(push_entry)
    );

    vwq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(host_accept), .push_entry(push_entry),
        .pop(fifo_pop), .mark(fifo_mark), .head(head),
        .empty(fifo_empty), .full(fifo_full)
    );

    vwq_slot #(.CRAM_DEPTH(CRAM_DEPTH), .VS_DEPTH(VS_DEPTH)) u_slot (
        .slot(slot_strobe), .rd_pend(rd_pend), .empty(fifo_empty), .head(head),
        .cyc(cyc), .we(mem_we), .tgt(tgt), .addr(mem_addr), .wdata(mem_wdata),
        .pop(fifo_pop), .mark(fifo_mark), .last_we(last_we), .unused(slot_unused)
    );

    assign mem_target = tgt;
endmodule

// File: rtl/vwq_checker.sv
module vwq_checker #(
    parameter int VS_DEPTH = 40
) (
    input logic        clk,
    input logic        rst,
    input logic        rd_req,
    input logic        rd_pend,
    input logic        slot_strobe,
    input logic        slot_unused,
    input logic        host_accept,
    input logic        mem_we,
    input logic [1:0]  mem_target,
    input logic [15:0] mem_addr,
    input logic        fifo_mark,
    input logic        fifo_empty,
    input logic        fifo_full,
    input logic [15:0] last_value
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> fifo_empty && !fifo_full && last_value == 16'h0);

    assert_no_push_full_R2: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> !host_accept);

    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(fifo_empty && fifo_full));

    assert_write_in_slot_R4: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> slot_strobe);

    assert_read_wins_R5: assert property (@(posedge clk) disable iff (rst)
        slot_strobe && rd_pend |-> slot_unused && !mem_we);

    assert_read_flag_clears_R5: assert property (@(posedge clk) disable iff (rst)
        slot_strobe && rd_pend && !rd_req |=> !rd_pend);

    assert_unused_no_write_R6: assert property (@(posedge clk) disable iff (rst)
        slot_unused |-> !mem_we);

    assert_vram_hold_R7: assert property (@(posedge clk) disable iff (rst)
        mem_we && mem_target == 2'd0 && fifo_mark |=> !fifo_empty);

    assert_vsram_range_R9: assert property (@(posedge clk) disable iff (rst)
        mem_we && mem_target == 2'd2 |-> int'(mem_addr) < VS_DEPTH);

    assert_last_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !mem_we |=> $stable(last_value));
endmodule

bind vmem_write_queue vwq_checker #(.VS_DEPTH(VS_DEPTH)) u_vwq_checker (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_pend(rd_pend),
    .slot_strobe(slot_strobe), .slot_unused(slot_unused), .host_accept(host_accept),
    .mem_we(mem_we), .mem_target(mem_target), .mem_addr(mem_addr),
    .fifo_mark(fifo_mark), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .last_value(last_value)
);

// File: tb/vmem_write_queue_bench.sv
module vmem_write_queue_bench;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 4;
    localparam int SETTLE = 2;
    localparam int VSD    = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_load = 0, dma_active = 0, host_wr = 0, rd_req = 0, slot_strobe = 0;
    logic [3:0]  cfg_code = 0;
    logic [15:0] cfg_addr = 0, host_data = 0;
    logic [7:0]  autoinc = 0;
    logic [1:0]  dma_mode = 0;
    logic        host_accept, slot_unused, mem_we, fifo_empty, fifo_full;
    logic [1:0]  mem_target;
    logic [15:0] mem_addr, mem_wdata, last_value;

    vmem_write_queue u_vmem_write_queue (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_code(cfg_code),
        .cfg_addr(cfg_addr), .autoinc(autoinc), .dma_active(dma_active),
        .dma_mode(dma_mode), .host_wr(host_wr), .host_data(host_data),
        .host_accept(host_accept), .rd_req(rd_req), .slot_strobe(slot_strobe),
        .slot_unused(slot_unused), .mem_we(mem_we), .mem_target(mem_target),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .last_value(last_value),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full)
    );

    always #(PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    typedef struct {
        int code;
        int addr;
        int value;
        int stamp;
        bit partial;
    } ment_t;

    ment_t q[$];
    int    m_code, m_addr, m_last, m_cyc;
    bit    m_rdp;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model: evaluated between edges, then advanced to the next cycle.
    always @(negedge clk) begin
        if (rst) begin
            chk("R1", "fifo_empty", int'(fifo_empty), 1);
            chk("R1", "fifo_full", int'(fifo_full), 0);
            chk("R1", "last_value", int'(last_value), 0);
            chk("R1", "mem_we", int'(mem_we), 0);
            q.delete();
            m_code = 0; m_addr = 0; m_last = 0; m_cyc = 0; m_rdp = 0;
        end else begin
            bit    e_acc, ready, serve, e_unused, e_we, do_pop, do_mark, do_last;
            int    e_tgt, e_addr, e_data, idx;
            string tag;
            e_acc = host_wr && !cfg_load && m_code[0] && q.size() < DEPTH
                    && !(dma_active && dma_mode != 2'b10);
            ready    = q.size() > 0 && (m_cyc - q[0].stamp) >= 0;
            serve    = slot_strobe && !m_rdp && ready;
            e_unused = slot_strobe && (m_rdp || !ready);
            e_we = 0; do_pop = 0; do_mark = 0; do_last = 0;
            e_tgt = 0; e_addr = 0; e_data = 0; tag = "R4";
            if (serve) begin
                idx = (q[0].addr >> 1) & 63;
                if (q[0].code == 1) begin
                    tag = "R7"; e_we = 1; e_tgt = 0;
                    if (!q[0].partial) begin
                        e_addr = q[0].addr; e_data = (q[0].value >> 8) & 255; do_mark = 1;
                    end else begin
                        e_addr = q[0].addr ^ 1; e_data = q[0].value & 255;
                        do_pop = 1; do_last = 1;
                    end
                end else if (q[0].code == 3) begin
                    tag = "R8"; e_we = 1; e_tgt = 1; e_addr = idx; e_data = q[0].value;
                    do_pop = 1; do_last = 1;
                end else if (q[0].code == 5) begin
                    tag = "R9"; do_pop = 1;
                    if (idx < VSD) begin
                        e_we = 1; e_tgt = 2; e_addr = idx; e_data = q[0].value; do_last = 1;
                    end
                end else begin
                    tag = "R11"; do_pop = 1;
                end
            end
            chk("R2", "host_accept", int'(host_accept), int'(e_acc));
            chk("R3", "fifo_empty", int'(fifo_empty), int'(q.size() == 0));
            chk("R3", "fifo_full", int'(fifo_full), int'(q.size() == DEPTH));
            chk(m_rdp ? "R5" : "R6", "slot_unused", int'(slot_unused), int'(e_unused));
            chk(tag, "mem_we", int'(mem_we), int'(e_we));
            if (e_we) begin
                chk(tag, "mem_target", int'(mem_target), e_tgt);
                chk(tag, "mem_addr", int'(mem_addr), e_addr);
                chk(tag, "mem_wdata", int'(mem_wdata), e_data);
            end
            chk("R10", "last_value", int'(last_value), m_last);
            // advance model
            if (do_last) m_last = q[0].value;
            if (do_mark) q[0].partial = 1;
            if (do_pop) void'(q.pop_front());
            if (slot_strobe && m_rdp) m_rdp = 0;
            if (rd_req) m_rdp = 1;
            if (cfg_load) begin
                m_code = int'(cfg_code); m_addr = int'(cfg_addr);
            end else if (e_acc) begin
                ment_t n;
                n.code = m_code; n.addr = m_addr; n.value = int'(host_data);
                n.stamp = m_cyc + SETTLE; n.partial = 0;
                q.push_back(n);
                m_addr = (m_addr + int'(autoinc)) & 16'hFFFF;
            end
            m_cyc++;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        cfg_load = 0; host_wr = 0; rd_req = 0; slot_strobe = 0;
    endtask

    task automatic load(input logic [3:0] c, input logic [15:0] a, input logic [7:0] inc);
        cfg_load = 1; cfg_code = c; cfg_addr = a; autoinc = inc;
        tick();
    endtask

    task automatic wr(input logic [15:0] d);
        host_wr = 1; host_data = d;
        tick();
    endtask

    task automatic slots(input int n);
        for (int i = 0; i < n; i++) begin
            slot_strobe = 1;
            tick();
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        #1;
        repeat (3) tick();
        rst = 0;
        // R7: VRAM byte pair, high first then low at address XOR 1
        load(4'h1, 16'h1000, 8'd2);
        wr(16'hABCD);
        wr(16'h1234);
        slots(8);
        // R8: CRAM word index
        load(4'h3, 16'h0086, 8'd2);
        wr(16'h0EEE);
        wr(16'h0123);
        tick(); tick();
        slots(4);
        // R9: VSRAM index 39 kept, 40 dropped
        load(4'h5, 16'h004E, 8'd2);
        wr(16'h03FF);
        wr(16'h0155);
        tick(); tick();
        slots(4);
        // R5: read pending wins the slot
        load(4'h3, 16'h0010, 8'd2);
        wr(16'h0777);
        rd_req = 1; tick();
        tick();
        slots(4);
        // R2: DMA blocking and fill mode
        dma_active = 1; dma_mode = 2'b00;
        wr(16'h1111);
        dma_mode = 2'b10;
        wr(16'h2222);
        dma_active = 0;
        // R2: read code ignores writes
        load(4'h0, 16'h0000, 8'd1);
        wr(16'h3333);
        slots(6);
        // R3: fill to full, extra write refused
        load(4'h3, 16'h0000, 8'd2);
        for (int i = 0; i < DEPTH + 2; i++) wr(16'(i + 16'h0100));
        slots(10);
        // R11: other odd code retired silently
        load(4'h7, 16'h0020, 8'd2);
        wr(16'h4444);
        tick(); tick();
        slots(3);
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(15) == 0) begin
                int c;
                c = $urandom_range(5);
                cfg_load = 1;
                cfg_code = (c == 0) ? 4'h0 : (c == 1) ? 4'h1 : (c == 2) ? 4'h3 :
                           (c == 3) ? 4'h5 : (c == 4) ? 4'h7 : 4'h8;
                cfg_addr = 16'($urandom);
                autoinc  = 8'($urandom_range(4));
            end
            host_wr     = ($urandom_range(1) == 1);
            host_data   = 16'($urandom);
            rd_req      = ($urandom_range(19) == 0);
            slot_strobe = ($urandom_range(2) == 0);
            dma_active  = ($urandom_range(9) == 0);
            dma_mode    = 2'($urandom);
            tick();
        end
        dma_active = 0;
        slots(20);
        finish_run();
    end
endmodule